// File: doc/BRIEF.md
# Statically Routed Virtual-Channel Mesh Router

This block is one router of a two-dimensional mesh that links the compute and memory tiles of a coarse-grained reconfigurable array. It has five flit ports: four neighbour directions and the local tile. Each flit carries a small virtual-channel (VC) id beside its payload. The router works out no routes at run time and allocates no VCs. Before execution, a configuration port loads a table with one entry for each (input port, incoming VC) pair. Each entry holds a valid bit, the output port and the VC that the flit takes on the next hop. On egress the router rewrites the flit's VC field with that next-hop VC.

Every input port has a separate FIFO for each VC. Each logical flow therefore keeps its own buffer on every link, and a stalled flow cannot hold up another flow. A round-robin switch allocator for each output port picks at most one head flit per cycle. It considers only heads whose downstream VC still has a credit. Flow control runs per hop and per VC. The router keeps one credit counter for each (output, downstream VC) and returns one credit upstream for each flit that leaves an input buffer. A flit that arrives on a pair with no valid table entry is dropped and sets a sticky error flag.

Top module: `rtr_static_vc`

## Requirements
- R1: After reset, tx_valid and rx_credit are all low and route_err is low. Every table entry is invalid, and every credit counter holds BUF_DEPTH.
- R2: Take a flit presented on input p with VC id v, where entry (p,v) is valid and the path has no contention and has credit. It leaves on the entry's output port with tx_vc equal to the entry's next-hop VC and the payload unchanged. tx_valid is high in the second cycle after the cycle in which the flit was presented.
- R3: The router drops a flit whose VC id is NVC or more, or whose entry is invalid. The flit produces no output and no credit, and route_err goes high and stays high until reset.
- R4: Each output port sends at most one flit per cycle. Input VCs that contend for it are served round-robin over slot index p*NVC+v, so K slots that request without pause are each served once in every K grants, on consecutive cycles.
- R5: A flit may leave toward downstream VC c of output o only while the credit counter for (o,c) is non-zero. Each send uses one credit, so without returns at most BUF_DEPTH flits go to one downstream VC.
- R6: Each one-cycle pulse on tx_credit[o][c] adds one credit and lets exactly one more waiting flit leave.
- R7: When a flit leaves the buffer of input VC (p,v), rx_credit[p][v] is high for one cycle, in the same cycle as the flit's tx_valid.
- R8: Each (port, VC) pair has its own FIFO of BUF_DEPTH flits. A VC that is blocked for lack of credits does not stall the other VCs of the same input port.
- R9: Flits from one input VC leave in the order in which they arrived.
- R10: With cfg_we high, entry (cfg_in_port, cfg_in_vc) takes cfg_ok, cfg_dst and cfg_nvc at the clock edge. Flits presented in later cycles follow the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_in_port | input | 3 | Input port of the entry being written |
| cfg_in_vc | input | 2 | Incoming VC of the entry being written |
| cfg_ok | input | 1 | Valid bit for the entry |
| cfg_dst | input | 3 | Output port for the entry |
| cfg_nvc | input | 2 | Next-hop VC for the entry |
| rx_valid | input | 5 | Flit present, one bit per input port |
| rx_vc | input | 5x2 | VC id of each incoming flit |
| rx_data | input | 5xFLIT_W | Payload of each incoming flit |
| rx_credit | output | 5xNVC | One-cycle credit pulse to upstream, per input port and VC |
| tx_valid | output | 5 | Flit sent, one bit per output port |
| tx_vc | output | 5x2 | Rewritten VC id of each outgoing flit |
| tx_data | output | 5xFLIT_W | Payload of each outgoing flit |
| tx_credit | input | 5xNVC | Credit pulse from downstream, per output port and VC |
| route_err | output | 1 | Sticky flag: a flit arrived on an unconfigured or out-of-range VC |

## Verification
The buffer and credit assertions assume that upstream senders obey their credits and never send to a full input VC. They also assume that downstream receivers return no more credits than flits received, and that every configured next-hop VC is below NVC. The stimulus keeps to these assumptions. It sends at most BUF_DEPTH flits per input VC before that VC drains, and it returns exactly one credit for every flit seen on an output. It writes only in-range next-hop VCs, and it sends out-of-range VC ids only to the ingress, where they must be dropped.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

    localparam int NPORT  = 5;
    localparam int PORT_W = 3;
    localparam int VC_W   = 2;

    // One routing table entry: valid, output port, next-hop VC.
    typedef struct packed {
        logic              ok;
        logic [PORT_W-1:0] dst;
        logic [VC_W-1:0]   nvc;
    } hop_t;

    function automatic int slot_of(input int port, input int vc, input int nvc);
        return port * nvc + vc;
    endfunction

endpackage

// File: rtl/rtr_vc_fifo.sv
module rtr_vc_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         nonempty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    assign rdata    = mem[rp];
    assign nonempty = (cnt != '0);

    // R5: upstream credits keep a full buffer from receiving a flit
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt != CW'(DEPTH)) || pop);

    // R9: the allocator pops only a buffer that holds a flit
    assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt != '0);

endmodule

// File: rtl/rtr_rr_arb.sv
module rtr_rr_arb #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr, win;
    logic [IW:0]   idx;

    always_comb begin
        gnt = '0;
        win = ptr;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            idx = {1'b0, ptr} + (IW+1)'(k);
            if (idx >= (IW+1)'(N)) idx = idx - (IW+1)'(N);
            if (gnt == '0 && req[idx[IW-1:0]]) begin
                gnt[idx[IW-1:0]] = 1'b1;
                win = idx[IW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        ptr <= '0;
        else if (|gnt)  ptr <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end

    // R4: one winner per output per cycle
    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R4: only a requesting slot may win
    assert_grant_requested_R4: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

endmodule

// File: rtl/rtr_credit_cnt.sv
module rtr_credit_cnt #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic give,
    output logic avail
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= CW'(DEPTH);
        else if (take && !give) cnt <= cnt - 1'b1;
        else if (give && !take) cnt <= cnt + 1'b1;
    end

    assign avail = (cnt != '0);

    // R5: no send toward a downstream VC with no credit left
    assert_credit_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        take |-> cnt != '0);

    // R6: downstream never returns more credits than its buffer depth
    assert_credit_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (give && !take) |-> cnt != CW'(DEPTH));

endmodule

// File: rtl/rtr_static_vc.sv
module rtr_static_vc
    import rtr_pkg::*;
#(
    parameter int NVC       = 2,
    parameter int FLIT_W    = 16,
    parameter int BUF_DEPTH = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we,
    input  logic [PORT_W-1:0]                  cfg_in_port,
    input  logic [VC_W-1:0]                    cfg_in_vc,
    input  logic                               cfg_ok,
    input  logic [PORT_W-1:0]                  cfg_dst,
    input  logic [VC_W-1:0]                    cfg_nvc,
    input  logic [NPORT-1:0]                   rx_valid,
    input  logic [NPORT-1:0][VC_W-1:0]         rx_vc,
    input  logic [NPORT-1:0][FLIT_W-1:0]       rx_data,
    output logic [NPORT-1:0][NVC-1:0]          rx_credit,
    output logic [NPORT-1:0]                   tx_valid,
    output logic [NPORT-1:0][VC_W-1:0]         tx_vc,
    output logic [NPORT-1:0][FLIT_W-1:0]       tx_data,
    input  logic [NPORT-1:0][NVC-1:0]          tx_credit,
    output logic                               route_err
);
    localparam int NSLOT = NPORT * NVC;

    hop_t              tbl       [NPORT][NVC];
    hop_t              head_hop  [NSLOT];
    logic [FLIT_W-1:0] head_data [NSLOT];
    logic [NSLOT-1:0]  push, pop, head_ok;
    logic [NPORT-1:0]  hit;
    logic [NSLOT-1:0]  req       [NPORT];
    logic [NSLOT-1:0]  gnt       [NPORT];
    logic [NPORT-1:0][NVC-1:0] cred_ok, cred_take;
    logic [FLIT_W-1:0] sel_data  [NPORT];
    logic [VC_W-1:0]   sel_vc    [NPORT];

    // Route table, written before traffic starts
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPORT; p++)
                for (int v = 0; v < NVC; v++)
                    tbl[p][v] <= '0;
        end else if (cfg_we) begin
            for (int p = 0; p < NPORT; p++)
                for (int v = 0; v < NVC; v++)
                    if (int'(cfg_in_port) == p && int'(cfg_in_vc) == v)
                        tbl[p][v] <= '{ok: cfg_ok, dst: cfg_dst, nvc: cfg_nvc};
        end
    end

    // Ingress: steer each flit to its VC buffer, or drop it
    always_comb begin
        hit  = '0;
        push = '0;
        for (int p = 0; p < NPORT; p++) begin
            for (int v = 0; v < NVC; v++) begin
                push[slot_of(p, v, NVC)] = rx_valid[p] && (int'(rx_vc[p]) == v) && tbl[p][v].ok;
                hit[p] = hit[p] | push[slot_of(p, v, NVC)];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                      route_err <= 1'b0;
        else if (|(rx_valid & ~hit))  route_err <= 1'b1;
    end

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_in
        for (genvar gv = 0; gv < NVC; gv++) begin : g_vc
            localparam int S = gp * NVC + gv;
            rtr_vc_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_fifo (
                .clk      (clk),
                .rst      (rst),
                .push     (push[S]),
                .wdata    (rx_data[gp]),
                .pop      (pop[S]),
                .rdata    (head_data[S]),
                .nonempty (head_ok[S])
            );
            assign head_hop[S] = tbl[gp][gv];
        end
    end

    for (genvar go = 0; go < NPORT; go++) begin : g_out
        for (genvar gc = 0; gc < NVC; gc++) begin : g_cr
            rtr_credit_cnt #(.DEPTH(BUF_DEPTH)) u_cred (
                .clk   (clk),
                .rst   (rst),
                .take  (cred_take[go][gc]),
                .give  (tx_credit[go][gc]),
                .avail (cred_ok[go][gc])
            );
        end
        rtr_rr_arb #(.N(NSLOT)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (req[go]),
            .gnt (gnt[go])
        );
    end

    // Requests: head present, aimed at this output, downstream VC has credit
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int s = 0; s < NSLOT; s++) begin
                req[o][s] = 1'b0;
                if (head_ok[s] && int'(head_hop[s].dst) == o)
                    for (int c = 0; c < NVC; c++)
                        if (int'(head_hop[s].nvc) == c && cred_ok[o][c])
                            req[o][s] = 1'b1;
            end
        end
    end

    // Winner selection: pop the buffer, spend the credit, mux the flit
    always_comb begin
        pop       = '0;
        cred_take = '0;
        for (int o = 0; o < NPORT; o++) begin
            sel_data[o] = '0;
            sel_vc[o]   = '0;
            for (int s = 0; s < NSLOT; s++) begin
                if (gnt[o][s]) begin
                    pop[s]      = 1'b1;
                    sel_data[o] = head_data[s];
                    sel_vc[o]   = head_hop[s].nvc;
                    for (int c = 0; c < NVC; c++)
                        if (int'(head_hop[s].nvc) == c) cred_take[o][c] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid  <= '0;
            rx_credit <= '0;
            for (int o = 0; o < NPORT; o++) begin
                tx_vc[o]   <= '0;
                tx_data[o] <= '0;
            end
        end else begin
            for (int o = 0; o < NPORT; o++) begin
                tx_valid[o] <= |gnt[o];
                tx_vc[o]    <= sel_vc[o];
                tx_data[o]  <= sel_data[o];
            end
            for (int p = 0; p < NPORT; p++)
                for (int v = 0; v < NVC; v++)
                    rx_credit[p][v] <= pop[slot_of(p, v, NVC)];
        end
    end

    // R3: the routing error flag holds until reset
    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        route_err |=> route_err);

    for (genvar ga = 0; ga < NPORT; ga++) begin : g_chk
        // R2: the rewritten VC field names an existing downstream VC
        assert_tx_vc_range_R2: assert property (@(posedge clk) disable iff (rst)
            tx_valid[ga] |-> int'(tx_vc[ga]) < NVC);
    end

endmodule

// File: tb/sim_rtr_static_vc.sv
module sim_rtr_static_vc;
    import rtr_pkg::*;

    localparam int NVC = 2;
    localparam int FW  = 16;

    logic                        clk = 1'b0;
    logic                        rst;
    logic                        cfg_we;
    logic [PORT_W-1:0]           cfg_in_port;
    logic [VC_W-1:0]             cfg_in_vc;
    logic                        cfg_ok;
    logic [PORT_W-1:0]           cfg_dst;
    logic [VC_W-1:0]             cfg_nvc;
    logic [NPORT-1:0]            rx_valid;
    logic [NPORT-1:0][VC_W-1:0]  rx_vc;
    logic [NPORT-1:0][FW-1:0]    rx_data;
    logic [NPORT-1:0][NVC-1:0]   rx_credit;
    logic [NPORT-1:0]            tx_valid;
    logic [NPORT-1:0][VC_W-1:0]  tx_vc;
    logic [NPORT-1:0][FW-1:0]    tx_data;
    logic [NPORT-1:0][NVC-1:0]   tx_credit;
    logic                        route_err;

    int n_chk = 0;
    int n_err = 0;

    rtr_static_vc #(.NVC(NVC), .FLIT_W(FW), .BUF_DEPTH(4)) u0 (
        .clk, .rst, .cfg_we, .cfg_in_port, .cfg_in_vc, .cfg_ok, .cfg_dst, .cfg_nvc,
        .rx_valid, .rx_vc, .rx_data, .rx_credit,
        .tx_valid, .tx_vc, .tx_data, .tx_credit, .route_err
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cfg(input int p, input int v, input bit ok, input int d, input int nv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_in_port = PORT_W'(p); cfg_in_vc = VC_W'(v);
        cfg_ok = ok; cfg_dst = PORT_W'(d); cfg_nvc = VC_W'(nv);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put(input int p, input int v, input int d);
        rx_valid[p] = 1'b1; rx_vc[p] = VC_W'(v); rx_data[p] = FW'(d);
    endtask

    task automatic give(input int o, input int c);
        @(negedge clk);
        tx_credit[o][c] = 1'b1;
        @(negedge clk);
        tx_credit = '0;
    endtask

    // Present one flit, then sample two edges later
    task automatic send_one(input int p, input int v, input int d);
        @(negedge clk);
        put(p, v, d);
        @(negedge clk);
        rx_valid = '0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int got;
        bit saw;
        int n, first, last, m0, m1, lo;
        int seq [6];

        rst = 1'b1; cfg_we = 0; cfg_in_port = '0; cfg_in_vc = '0; cfg_ok = 0;
        cfg_dst = '0; cfg_nvc = '0; rx_valid = '0; rx_vc = '0; rx_data = '0; tx_credit = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check("R1", "tx_valid", int'(tx_valid), 0);
        check("R1", "rx_credit", int'(rx_credit), 0);
        check("R1", "route_err", int'(route_err), 0);

        // R2/R7/R10: sweep all (port, VC) pairs through their own routes
        for (int p = 0; p < NPORT; p++)
            for (int v = 0; v < NVC; v++)
                cfg(p, v, 1'b1, (p + 1 + v) % NPORT, v ^ 1);
        for (int p = 0; p < NPORT; p++) begin
            for (int v = 0; v < NVC; v++) begin
                automatic int d  = (p + 1 + v) % NPORT;
                automatic int nv = v ^ 1;
                automatic int dat = 'h5000 + p * 256 + v * 16;
                send_one(p, v, dat);
                check("R2", "tx_valid port", int'(tx_valid), 1 << d);
                check("R2", "tx_vc rewrite", int'(tx_vc[d]), nv);
                check("R2", "payload", int'(tx_data[d]), dat);
                check("R7", "rx_credit", int'(rx_credit), 1 << (p * NVC + v));
                give(d, nv);
            end
        end

        // R3: invalid entry drops the flit and sets the sticky flag
        cfg(2, 1, 1'b0, 0, 0);
        send_one(2, 1, 'h1234);
        check("R3", "no egress", int'(tx_valid), 0);
        check("R3", "no credit", int'(rx_credit), 0);
        check("R3", "route_err set", int'(route_err), 1);
        cfg(2, 1, 1'b1, 4, 0);

        // R5/R8/R9: (0,0) -> port 1 VC 1 with 4 credits, 6 flits offered
        got = 0; saw = 0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (tx_valid[1]) begin
                check("R9", "order on VC", int'(tx_data[1]), 'h6000 + got);
                got++;
            end
            if (tx_valid[2] && tx_data[2] == 16'h7000) saw = 1;
            rx_valid = '0;
            if (i < 6)  put(0, 0, 'h6000 + i);
            if (i == 8) put(0, 1, 'h7000);
        end
        check("R5", "sends limited by credits", got, 4);
        check("R8", "other VC not blocked", int'(saw), 1);
        // R6: each returned credit releases exactly one flit
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (tx_valid[1]) begin
                    check("R9", "order after credit", int'(tx_data[1]), 'h6000 + got);
                    got++;
                end
                tx_credit = '0;
                if (i == 0) tx_credit[1][1] = 1'b1;
            end
            check("R6", "released count", got, 5 + r);
        end
        for (int k = 0; k < 4; k++) give(1, 1);
        give(2, 0);

        // R4: three input VCs contend for output 3
        cfg(1, 0, 1'b1, 3, 0);
        cfg(2, 0, 1'b1, 3, 1);
        cfg(4, 0, 1'b1, 3, 0);
        n = 0; first = -1; last = -1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (tx_valid[3]) begin
                automatic int src = (int'(tx_data[3]) >> 4) & 15;
                if (n < 6) seq[n] = int'(tx_data[3]);
                check("R2", "vc under contention", int'(tx_vc[3]), (src == 2) ? 1 : 0);
                if (first < 0) first = i;
                last = i;
                n++;
            end
            rx_valid = '0;
            if (i < 2) begin
                put(1, 0, 'h8010 + i);
                put(2, 0, 'h8020 + i);
                put(4, 0, 'h8040 + i);
            end
        end
        check("R4", "flit count", n, 6);
        check("R4", "back to back", last - first, 5);
        m0 = 0; m1 = 0; lo = 0;
        for (int k = 0; k < 3; k++) begin
            m0 |= 1 << ((seq[k] >> 4) & 15);
            m1 |= 1 << ((seq[k + 3] >> 4) & 15);
            lo |= seq[k] & 15;
        end
        check("R4", "first round mask", m0, 'h16);
        check("R4", "second round mask", m1, 'h16);
        check("R9", "first flits lead", lo, 0);
        for (int k = 0; k < 4; k++) give(3, 0);
        for (int k = 0; k < 2; k++) give(3, 1);

        // R10: rewrite an entry and follow the new route
        cfg(0, 1, 1'b1, 4, 1);
        send_one(0, 1, 'h9001);
        check("R10", "new port", int'(tx_valid), 1 << 4);
        check("R10", "new vc", int'(tx_vc[4]), 1);
        check("R3", "flag still held", int'(route_err), 1);
        give(4, 1);

        // R1: reset clears the flag and the table
        do_reset();
        check("R1", "route_err cleared", int'(route_err), 0);
        send_one(1, 0, 'hA000);
        check("R1", "table invalid after reset", int'(tx_valid), 0);
        check("R1", "unrouted flag", int'(route_err), 1);

        // R3: out-of-range VC id is dropped
        do_reset();
        cfg(0, 0, 1'b1, 2, 0);
        send_one(0, 2, 'hB000);
        check("R3", "range drop egress", int'(tx_valid), 0);
        check("R3", "range drop flag", int'(route_err), 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule